// File: doc/BRIEF.md
# Cyclic (7,4) Single-Error-Correcting Codec

This block pairs an encoder and a corrector for a systematic (7,4) cyclic code built on the generator polynomial g(x) = x^3 + x + 1. The encoder takes a 4-bit data nibble and emits a 7-bit codeword. The nibble sits in the upper four bits. The low three bits are the remainder left after the nibble, raised by x^3, is divided by g(x). The code rate is 4/7.

The corrector takes a received 7-bit word and divides it by g(x) to get a 3-bit syndrome. A zero syndrome means the word is a valid codeword. A non-zero syndrome names exactly one bit position, which the corrector inverts before returning the upper four bits as data. It also reports the syndrome and an error flag. The two paths are independent. Each is combinational logic followed by one register stage, with its valid strobe delayed to match.

Top module: `cyc74_codec`

## Requirements
- R1: After reset, and until the first accepted input, every output is zero: both valid outputs, `enc_code`, `dec_data`, `dec_syndrome` and `dec_error`.
- R2: A codeword carries the data nibble unchanged in bits [6:3] (`enc_code[6:3] = enc_data`).
- R3: Codeword bits [2:0] are the remainder of m(x)·x^3 divided by x^3+x+1, where bit i of a word is the coefficient of x^i. For example, data 0001 gives 0001011 and data 0010 gives 0010110.
- R4: `enc_out_valid` is high in the cycle after each cycle in which `enc_in_valid` is high, and low otherwise. `enc_code` is updated on that same edge.
- R5: `dec_syndrome` is the remainder of the received word divided by x^3+x+1. It is 000 for every valid codeword, and in that case `dec_error` is 0 and `dec_data` equals bits [6:3] of the received word.
- R6: A single flipped bit at position 0,1,2,3,4,5,6 gives syndrome 001,010,100,011,110,111,101 respectively, and `dec_error` is 1.
- R7: When one bit is flipped, the corrector inverts the bit that the syndrome names, so `dec_data` equals the original data nibble.
- R8: `dec_out_valid` is high in the cycle after each cycle in which `dec_in_valid` is high, and low otherwise.
- R9: While its input valid is low, each path ignores its data input, so its data outputs hold their last values.
- R10: The syndrome depends only on the error pattern: the same flipped position gives the same syndrome for every transmitted codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_in_valid | input | 1 | Encoder input strobe |
| enc_data | input | 4 | Data nibble to encode |
| enc_out_valid | output | 1 | Encoder output strobe |
| enc_code | output | 7 | Codeword: data in [6:3], parity in [2:0] |
| dec_in_valid | input | 1 | Corrector input strobe |
| dec_word | input | 7 | Received word |
| dec_out_valid | output | 1 | Corrector output strobe |
| dec_data | output | 4 | Corrected data nibble |
| dec_syndrome | output | 3 | Remainder of the received word divided by g(x) |
| dec_error | output | 1 | High when the syndrome is non-zero |

## Verification
The bench encodes all sixteen nibbles. It then corrupts every codeword at each of the seven positions and checks both the syndrome and the recovered nibble. This catches three faults:
- A wrong parity tap, which makes clean codewords produce non-zero syndromes.
- A swapped entry in the syndrome-to-position map, which flips a correct bit and corrupts the data.
- A map that treats syndrome 000 as a position, which damages clean words.

The two stated codewords pin down the bit ordering. Idle cycles with changing inputs would expose registers that load without a strobe. Back-to-back and gapped strobes would expose a valid output that sticks high or is not delayed.

// File: rtl/cyc74_codec.sv
module cyc74_codec #(
  parameter int N = 7,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enc_in_valid,
  input  logic [K-1:0] enc_data,
  output logic         enc_out_valid,
  output logic [N-1:0] enc_code,
  input  logic         dec_in_valid,
  input  logic [N-1:0] dec_word,
  output logic         dec_out_valid,
  output logic [K-1:0] dec_data,
  output logic [N-K-1:0] dec_syndrome,
  output logic         dec_error
);
  localparam int R = N - K;
  localparam logic [R:0] GEN = 4'b1011;

  function automatic logic [R-1:0] rem_g(input logic [N-1:0] w);
    logic [N-1:0] t;
    t = w;
    for (int i = N - 1; i >= R; i--)
      if (t[i]) t = t ^ (N'(GEN) << (i - R));
    return t[R-1:0];
  endfunction

  function automatic logic [N-1:0] pos_mask(input logic [R-1:0] s);
    logic [N-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++)
      if (s != '0 && rem_g(N'(1) << i) == s) m[i] = 1'b1;
    return m;
  endfunction

  logic [N-1:0] code_c;
  logic [R-1:0] syn_c;
  logic [N-1:0] fixed_c;

  assign code_c  = {enc_data, rem_g({enc_data, {R{1'b0}}})};
  assign syn_c   = rem_g(dec_word);
  assign fixed_c = dec_word ^ pos_mask(syn_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_out_valid <= 1'b0;
      enc_code      <= '0;
    end else begin
      enc_out_valid <= enc_in_valid;
      if (enc_in_valid) enc_code <= code_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_out_valid <= 1'b0;
      dec_data      <= '0;
      dec_syndrome  <= '0;
      dec_error     <= 1'b0;
    end else begin
      dec_out_valid <= dec_in_valid;
      if (dec_in_valid) begin
        dec_data     <= fixed_c[N-1:R];
        dec_syndrome <= syn_c;
        dec_error    <= |syn_c;
      end
    end
  end
endmodule

// File: rtl/cyc74_codec_chk.sv
module cyc74_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enc_in_valid,
  input logic [3:0] enc_data,
  input logic       enc_out_valid,
  input logic [6:0] enc_code,
  input logic       dec_in_valid,
  input logic [6:0] dec_word,
  input logic       dec_out_valid,
  input logic [3:0] dec_data,
  input logic [2:0] dec_syndrome,
  input logic       dec_error
);
  function automatic logic [2:0] divrem(input logic [6:0] w);
    logic [6:0] t;
    t = w;
    for (int i = 6; i >= 3; i--)
      if (t[i]) t = t ^ (7'b0001011 << (i - 3));
    return t[2:0];
  endfunction

  assert_enc_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enc_in_valid |=> enc_code[6:3] == $past(enc_data));
  assert_enc_divisible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> divrem(enc_code) == 3'b000);
  assert_enc_valid_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enc_in_valid |=> enc_out_valid);
  assert_enc_valid_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_in_valid |=> !enc_out_valid);
  assert_dec_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_in_valid && divrem(dec_word) == 3'b000) |=>
      (!dec_error && dec_syndrome == 3'b000 && dec_data == $past(dec_word[6:3])));
  assert_dec_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_in_valid && divrem(dec_word) != 3'b000) |=> dec_error);
  assert_dec_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_in_valid |=> dec_out_valid);
  assert_enc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_in_valid |=> $stable(enc_code));
  assert_dec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_in_valid |=> ($stable(dec_data) && $stable(dec_syndrome) && $stable(dec_error)));
endmodule

bind cyc74_codec cyc74_codec_chk u_chk (.*);

// File: tb/tb_cyc74_codec.sv
`timescale 1ns/1ps
module tb_cyc74_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_in_valid = 1'b0;
  logic [3:0] enc_data = '0;
  logic       enc_out_valid;
  logic [6:0] enc_code;
  logic       dec_in_valid = 1'b0;
  logic [6:0] dec_word = '0;
  logic       dec_out_valid;
  logic [3:0] dec_data;
  logic [2:0] dec_syndrome;
  logic       dec_error;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cyc74_codec dut (.*);

  function automatic logic [2:0] exp_parity(input logic [3:0] d);
    logic [2:0] p;
    p = 3'b000;
    if (d[0]) p ^= 3'b011;
    if (d[1]) p ^= 3'b110;
    if (d[2]) p ^= 3'b111;
    if (d[3]) p ^= 3'b101;
    return p;
  endfunction

  function automatic logic [2:0] exp_syn(input int pos);
    case (pos)
      0: return 3'b001;
      1: return 3'b010;
      2: return 3'b100;
      3: return 3'b011;
      4: return 3'b110;
      5: return 3'b111;
      default: return 3'b101;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic enc_one(input logic [3:0] d);
    @(negedge clk);
    enc_in_valid = 1'b1;
    enc_data = d;
    @(negedge clk);
    enc_in_valid = 1'b0;
  endtask

  task automatic dec_one(input logic [6:0] w);
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_word = w;
    @(negedge clk);
    dec_in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check(enc_out_valid == 0 && dec_out_valid == 0, "R1 valids", {enc_out_valid, dec_out_valid}, 0);
    check(enc_code == 0, "R1 enc_code", enc_code, 0);
    check(dec_data == 0 && dec_syndrome == 0 && dec_error == 0, "R1 dec outputs",
          {dec_data, dec_syndrome, dec_error}, 0);
  endtask

  task automatic t_known;
    enc_one(4'b0001);
    check(enc_code == 7'b0001011, "R3 data 0001", enc_code, 7'b0001011);
    enc_one(4'b0010);
    check(enc_code == 7'b0010110, "R3 data 0010", enc_code, 7'b0010110);
  endtask

  task automatic t_encode_all;
    for (int d = 0; d < 16; d++) begin
      enc_one(4'(d));
      check(enc_out_valid == 1'b1, "R4 valid after strobe", enc_out_valid, 1);
      check(enc_code[6:3] == 4'(d), "R2 data field", enc_code[6:3], d);
      check(enc_code[2:0] == exp_parity(4'(d)), "R3 parity", enc_code[2:0], exp_parity(4'(d)));
    end
    @(negedge clk);
    check(enc_out_valid == 1'b0, "R4 valid drops", enc_out_valid, 0);
  endtask

  task automatic t_clean;
    for (int d = 0; d < 16; d++) begin
      dec_one({4'(d), exp_parity(4'(d))});
      check(dec_out_valid == 1'b1, "R8 valid after strobe", dec_out_valid, 1);
      check(dec_syndrome == 3'b000 && dec_error == 1'b0, "R5 clean syndrome",
            {dec_syndrome, dec_error}, 0);
      check(dec_data == 4'(d), "R5 clean data", dec_data, d);
    end
    @(negedge clk);
    check(dec_out_valid == 1'b0, "R8 valid drops", dec_out_valid, 0);
  endtask

  task automatic t_single;
    for (int d = 0; d < 16; d++)
      for (int p = 0; p < 7; p++) begin
        dec_one({4'(d), exp_parity(4'(d))} ^ (7'b1 << p));
        check(dec_syndrome == exp_syn(p), "R6 R10 syndrome", dec_syndrome, exp_syn(p));
        check(dec_error == 1'b1, "R6 error flag", dec_error, 1);
        check(dec_data == 4'(d), "R7 corrected data", dec_data, d);
      end
  endtask

  task automatic t_hold;
    enc_one(4'b1010);
    dec_one(7'b1010011 ^ 7'b0100000);
    @(negedge clk);
    enc_data = 4'b0101;
    dec_word = 7'b0000001;
    @(negedge clk);
    enc_data = 4'b1111;
    dec_word = 7'b1000000;
    @(negedge clk);
    check(enc_code == {4'b1010, exp_parity(4'b1010)}, "R9 enc hold", enc_code, {4'b1010, exp_parity(4'b1010)});
    check(dec_data == 4'b1010 && dec_syndrome == exp_syn(5) && dec_error == 1'b1, "R9 dec hold",
          {dec_data, dec_syndrome, dec_error}, {4'b1010, exp_syn(5), 1'b1});
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    enc_in_valid = 1'b1;
    enc_data = 4'b0011;
    dec_in_valid = 1'b1;
    dec_word = {4'b0110, exp_parity(4'b0110)} ^ 7'b0001000;
    @(negedge clk);
    check(enc_out_valid && enc_code == {4'b0011, exp_parity(4'b0011)}, "R4 first of pair",
          enc_code, {4'b0011, exp_parity(4'b0011)});
    check(dec_out_valid && dec_data == 4'b0110, "R8 R7 first of pair", dec_data, 4'b0110);
    enc_data = 4'b1100;
    dec_word = {4'b1001, exp_parity(4'b1001)};
    @(negedge clk);
    enc_in_valid = 1'b0;
    dec_in_valid = 1'b0;
    check(enc_out_valid && enc_code == {4'b1100, exp_parity(4'b1100)}, "R4 second of pair",
          enc_code, {4'b1100, exp_parity(4'b1100)});
    check(dec_out_valid && dec_data == 4'b1001 && !dec_error, "R8 R5 second of pair",
          {dec_data, dec_error}, {4'b1001, 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_known;
    t_encode_all;
    t_clean;
    t_single;
    t_hold;
    t_back_to_back;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule